// File: doc/BRIEF.md
# Segment Selector Translation Unit

This block turns a logical address (a 16-bit selector and a 32-bit offset) into a 32-bit linear address. It splits the selector into a descriptor index, a table choice and a requested privilege. It checks that the indexed entry lies inside the chosen table, then reads the 8-byte entry as two 32-bit words through a simple memory port. It unpacks the segment base, the 20-bit limit and the attribute bits, checks them against the request, and returns either the base-plus-offset address or a coded fault.

A request is taken with a one-cycle `start` pulse while the unit is idle. Completion is signalled by a one-cycle `done` pulse. `fault`, `fault_code` and `lin_addr` are updated at that moment and hold their values until the next completion. When a translation succeeds and the entry's accessed bit is clear, the unit writes the upper descriptor word back with that bit set, in the same cycle as `done`.

Top module: `seg_xlate`

## Requirements
- R1: Selector bits [15:3] are the index, bit 2 picks the table (0 global, 1 local), bits [1:0] are the requested privilege; the entry's low word is read at table base + 8*index and its high word at that address + 4, on consecutive cycles.
- R2: A `start` is accepted only while idle; a `start` during a translation has no effect. A fetched translation raises `done` for one cycle after the fourth rising edge counted from the edge that samples `start`; a table-bound fault raises it after the first.
- R3: If 8*index + 7 exceeds the chosen table limit, the result is fault code 1 and no memory read is issued.
- R4: The descriptor layout is as follows. Low word: [15:0] limit low, [31:16] base low. High word: [7:0] base middle, [8] accessed, [12] S, [14:13] DPL, [15] present, [19:16] limit high, [23] granularity, [31:24] base high.
- R5: On success, `fault` is 0, `fault_code` is 0 and `lin_addr` is base + offset, modulo 2^32.
- R6: A descriptor whose present bit is 0 gives fault code 2.
- R7: A descriptor with S = 0 (system type) gives fault code 3.
- R8: If the larger of the current privilege and the requested privilege is numerically above DPL, the result is fault code 4.
- R9: The effective limit is the 20-bit limit when granularity is 0, and limit*4096 + 4095 when it is 1. An offset above the effective limit gives fault code 5.
- R10: When several causes apply, the reported code follows the order table-bound, not-present, system, privilege, limit.
- R11: On success with the accessed bit clear, the unit writes the high word with bit 8 set to the high-word address in the `done` cycle. It makes no write when the bit is already set or when the translation faults.
- R12: After reset, `done`, `fault`, `mem_rd_en` and `mem_wr_en` are low, and `fault_code` and `lin_addr` are zero. On any fault, `lin_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken when idle |
| selector | input | 16 | Segment selector |
| offset | input | 32 | Offset within the segment |
| cpl | input | 2 | Current privilege level |
| gdt_base | input | 32 | Global table base address |
| gdt_limit | input | 16 | Global table last valid byte |
| ldt_base | input | 32 | Local table base address |
| ldt_limit | input | 16 | Local table last valid byte |
| mem_rd_en | output | 1 | Read strobe, data expected one cycle later |
| mem_wr_en | output | 1 | Write strobe for accessed-bit update |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last translation faulted |
| fault_code | output | 3 | Last fault cause (0 none) |
| lin_addr | output | 32 | Last linear address |

## Verification
The completion pulse and the accessed-bit write-back fall in the same cycle: both are decided in the cycle the high descriptor word returns. Random descriptors with the accessed bit clear or set, mixed with faults of every kind, provoke the case. At each completion the bench checks the reported result against its own model, and it checks whether a write was made, with which address and data, against whether the model expects success with the bit clear. It then checks that the table word in memory now holds the bit.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int LIN_W   = 32;
  localparam int LIM_W   = 20;
  localparam int PAGE_SH = 12;
  localparam int ACC_BIT = 8;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_BOUND   = 3'd1,
    FLT_NOTPRES = 3'd2,
    FLT_SYSTEM  = 3'd3,
    FLT_PRIV    = 3'd4,
    FLT_LIMIT   = 3'd5
  } fault_e;

  typedef struct packed {
    logic [LIN_W-1:0] base;
    logic [LIM_W-1:0] limit;
    logic             gran;
    logic             present;
    logic             code_data;
    logic [1:0]       dpl;
    logic             accessed;
  } desc_t;
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode #(
  parameter int IDX_W     = 13,
  parameter int TBL_LIM_W = 16,
  parameter int ADDR_W    = 32
) (
  input  logic [IDX_W+2:0]     sel,
  input  logic [ADDR_W-1:0]    gbase,
  input  logic [TBL_LIM_W-1:0] glim,
  input  logic [ADDR_W-1:0]    lbase,
  input  logic [TBL_LIM_W-1:0] llim,
  output logic [ADDR_W-1:0]    fetch_addr,
  output logic                 in_bounds,
  output logic [1:0]           rpl
);
  localparam int ENT_W = IDX_W + 3;

  logic [IDX_W-1:0]     idx;
  logic                 use_local;
  logic [ENT_W-1:0]     last_byte;
  logic [ADDR_W-1:0]    tbase;
  logic [TBL_LIM_W-1:0] tlim;

  always_comb begin
    idx        = sel[ENT_W-1:3];
    use_local  = sel[2];
    rpl        = sel[1:0];
    tbase      = use_local ? lbase : gbase;
    tlim       = use_local ? llim  : glim;
    last_byte  = {idx, 3'b111};
    in_bounds  = (ADDR_W'(last_byte) <= ADDR_W'(tlim));
    fetch_addr = tbase + ADDR_W'({idx, 3'b000});
  end
endmodule

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
  import seg_xlate_pkg::*;
(
  input  logic [31:0] lo,
  input  logic [31:0] hi,
  output desc_t       d
);
  logic unused_hi_bits;

  always_comb begin
    d.base      = {hi[31:24], hi[7:0], lo[31:16]};
    d.limit     = {hi[19:16], lo[15:0]};
    d.gran      = hi[23];
    d.present   = hi[15];
    d.dpl       = hi[14:13];
    d.code_data = hi[12];
    d.accessed  = hi[ACC_BIT];
  end

  assign unused_hi_bits = ^{hi[22:20], hi[11:9]};
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import seg_xlate_pkg::*;
(
  input  desc_t            d,
  input  logic [LIN_W-1:0] offset,
  input  logic [1:0]       cpl,
  input  logic [1:0]       rpl,
  output fault_e           code,
  output logic [LIN_W-1:0] lin
);
  logic [LIN_W-1:0] eff_lim;
  logic [1:0]       eff_pl;
  logic             unused_acc;

  always_comb begin
    eff_pl  = (cpl > rpl) ? cpl : rpl;
    eff_lim = d.gran ? {d.limit, {PAGE_SH{1'b1}}}
                     : {{(LIN_W-LIM_W){1'b0}}, d.limit};
    if (!d.present)            code = FLT_NOTPRES;
    else if (!d.code_data)     code = FLT_SYSTEM;
    else if (eff_pl > d.dpl)   code = FLT_PRIV;
    else if (offset > eff_lim) code = FLT_LIMIT;
    else                       code = FLT_NONE;
    lin = d.base + offset;
  end

  assign unused_acc = d.accessed;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int IDX_W     = 13,
  parameter int TBL_LIM_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [IDX_W+2:0]     selector,
  input  logic [LIN_W-1:0]     offset,
  input  logic [1:0]           cpl,
  input  logic [LIN_W-1:0]     gdt_base,
  input  logic [TBL_LIM_W-1:0] gdt_limit,
  input  logic [LIN_W-1:0]     ldt_base,
  input  logic [TBL_LIM_W-1:0] ldt_limit,
  output logic                 mem_rd_en,
  output logic                 mem_wr_en,
  output logic [LIN_W-1:0]     mem_addr,
  output logic [LIN_W-1:0]     mem_wdata,
  input  logic [LIN_W-1:0]     mem_rdata,
  output logic                 done,
  output logic                 fault,
  output logic [2:0]           fault_code,
  output logic [LIN_W-1:0]     lin_addr
);
  localparam logic [LIN_W-1:0] WORD_STEP = LIN_W'(4);
  localparam logic [LIN_W-1:0] ACC_MASK  = LIN_W'(1) << ACC_BIT;

  typedef enum logic [1:0] {ST_IDLE, ST_RD_HI, ST_CAP_LO, ST_EVAL} state_e;

  state_e           state;
  logic [LIN_W-1:0] lo_q;
  logic [LIN_W-1:0] off_q;
  logic [1:0]       cpl_q;
  logic [1:0]       rpl_q;

  logic [LIN_W-1:0] fetch_addr;
  logic             in_bounds;
  logic [1:0]       sel_rpl;
  desc_t            desc;
  fault_e           chk_code;
  logic [LIN_W-1:0] chk_lin;

  seg_sel_decode #(
    .IDX_W(IDX_W), .TBL_LIM_W(TBL_LIM_W), .ADDR_W(LIN_W)
  ) u_dec (
    .sel(selector), .gbase(gdt_base), .glim(gdt_limit),
    .lbase(ldt_base), .llim(ldt_limit),
    .fetch_addr(fetch_addr), .in_bounds(in_bounds), .rpl(sel_rpl)
  );

  seg_desc_unpack u_unpack (.lo(lo_q), .hi(mem_rdata), .d(desc));

  seg_access_check u_chk_logic (
    .d(desc), .offset(off_q), .cpl(cpl_q), .rpl(rpl_q),
    .code(chk_code), .lin(chk_lin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mem_rd_en  <= 1'b0;
      mem_wr_en  <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_code <= FLT_NONE;
      lin_addr   <= '0;
      lo_q       <= '0;
      off_q      <= '0;
      cpl_q      <= '0;
      rpl_q      <= '0;
    end else begin
      done      <= 1'b0;
      mem_wr_en <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            off_q <= offset;
            cpl_q <= cpl;
            rpl_q <= sel_rpl;
            if (!in_bounds) begin
              done       <= 1'b1;
              fault      <= 1'b1;
              fault_code <= FLT_BOUND;
              lin_addr   <= '0;
            end else begin
              mem_rd_en <= 1'b1;
              mem_addr  <= fetch_addr;
              state     <= ST_RD_HI;
            end
          end
        end
        ST_RD_HI: begin
          mem_rd_en <= 1'b1;
          mem_addr  <= mem_addr + WORD_STEP;
          state     <= ST_CAP_LO;
        end
        ST_CAP_LO: begin
          mem_rd_en <= 1'b0;
          lo_q      <= mem_rdata;
          state     <= ST_EVAL;
        end
        ST_EVAL: begin
          done       <= 1'b1;
          fault      <= (chk_code != FLT_NONE);
          fault_code <= chk_code;
          lin_addr   <= (chk_code == FLT_NONE) ? chk_lin : '0;
          if (chk_code == FLT_NONE && !desc.accessed) begin
            mem_wr_en <= 1'b1;
            mem_wdata <= mem_rdata | ACC_MASK;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst,
  input logic        mem_rd_en,
  input logic        mem_wr_en,
  input logic [31:0] mem_wdata,
  input logic        done,
  input logic        fault,
  input logic [2:0]  fault_code,
  input logic [31:0] lin_addr
);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_no_read_at_done_R2: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !done);

  assert_two_word_read_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_en) |=> mem_rd_en);

  assert_write_only_success_R11: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (done && !fault));

  assert_write_sets_bit_R11: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> mem_wdata[8]);

  assert_rd_wr_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));

  assert_fault_zero_lin_R12: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (lin_addr == 32'd0));

  assert_code_matches_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !fault) |-> (fault_code == 3'd0));
endmodule

bind seg_xlate seg_xlate_chk u_chk (.*);

// File: tb/seg_xlate_bench.sv
`timescale 1ns/1ps
module seg_xlate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] selector = '0;
  logic [31:0] offset = '0;
  logic [1:0]  cpl = '0;
  logic [31:0] gdt_base = 32'h0;
  logic [15:0] gdt_limit = 16'h007F;
  logic [31:0] ldt_base = 32'h200;
  logic [15:0] ldt_limit = 16'h003F;
  logic        mem_rd_en, mem_wr_en, done, fault;
  logic [31:0] mem_addr, mem_wdata, lin_addr;
  logic [31:0] mem_rdata = '0;
  logic [2:0]  fault_code;

  always #2 clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk(clk), .rst(rst), .start(start), .selector(selector), .offset(offset),
    .cpl(cpl), .gdt_base(gdt_base), .gdt_limit(gdt_limit), .ldt_base(ldt_base),
    .ldt_limit(ldt_limit), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .fault_code(fault_code), .lin_addr(lin_addr)
  );

  logic [31:0] mem [0:255];
  int rd_cnt, wr_cnt, done_cnt;
  logic [31:0] rd_addr0, rd_addr1, wr_addr, wr_data;
  int checks = 0, failures = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= mem[mem_addr[9:2]];
      if (rd_cnt == 0) rd_addr0 = mem_addr;
      if (rd_cnt == 1) rd_addr1 = mem_addr;
      rd_cnt++;
    end
    if (mem_wr_en) begin
      mem[mem_addr[9:2]] <= mem_wdata;
      wr_addr = mem_addr; wr_data = mem_wdata; wr_cnt++;
    end
    if (done) done_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_lo(input logic [31:0] b, input logic [19:0] l);
    return {b[15:0], l[15:0]};
  endfunction
  function automatic logic [31:0] mk_hi(input logic [31:0] b, input logic [19:0] l,
      input bit g, input bit p, input bit s, input logic [1:0] dpl, input bit a);
    return {b[31:24], g, 3'b000, l[19:16], p, dpl, s, 3'b001, a, b[23:16]};
  endfunction

  function automatic logic [31:0] ent_addr(input logic [15:0] s);
    return (s[2] ? ldt_base : gdt_base) + {16'd0, s[15:3], 3'b000};
  endfunction

  task automatic put_desc(input logic [15:0] s, input logic [31:0] lo, input logic [31:0] hi);
    logic [31:0] a;
    a = ent_addr(s);
    mem[a[9:2]] = lo;
    mem[a[9:2] + 8'd1] = hi;
  endtask

  // Reference model from R3, R5-R10
  function automatic logic [2:0] exp_code(input logic [15:0] s, input logic [31:0] lo,
      input logic [31:0] hi, input logic [31:0] off, input logic [1:0] c);
    logic [31:0] last, lim, eff;
    logic [1:0] pl;
    last = {16'd0, s[15:3], 3'b111};
    lim  = {16'd0, s[2] ? ldt_limit : gdt_limit};
    if (last > lim) return 3'd1;
    if (!hi[15]) return 3'd2;
    if (!hi[12]) return 3'd3;
    pl = (c > s[1:0]) ? c : s[1:0];
    if (pl > hi[14:13]) return 3'd4;
    eff = hi[23] ? {hi[19:16], lo[15:0], 12'hFFF} : {12'd0, hi[19:16], lo[15:0]};
    if (off > eff) return 3'd5;
    return 3'd0;
  endfunction

  task automatic run_req(input logic [15:0] s, input logic [31:0] off, input logic [1:0] c,
      input bit poke, input string tag);
    logic [31:0] a, lo, hi, exp_lin;
    logic [2:0] ec;
    int lat;
    a = ent_addr(s);
    lo = mem[a[9:2]];
    hi = mem[a[9:2] + 8'd1];
    ec = exp_code(s, lo, hi, off, c);
    exp_lin = (ec == 3'd0) ? ({hi[31:24], hi[7:0], lo[31:16]} + off) : 32'd0;
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0;
    @(negedge clk);
    selector = s; offset = off; cpl = c; start = 1'b1;
    @(posedge clk); lat = 1;
    @(negedge clk); start = 1'b0;
    while (!done && lat < 20) begin
      if (poke && lat == 1) begin selector = 16'hFFF8; offset = 32'h0; start = 1'b1; end
      @(posedge clk); lat++;
      @(negedge clk); start = 1'b0;
    end
    chk(lat < 20, {"R2 done arrives ", tag}, lat, 4);
    chk(fault_code == ec, {"R10 fault code ", tag}, {29'd0, fault_code}, {29'd0, ec});
    chk(fault == (ec != 0), {"R5 fault flag ", tag}, {31'd0, fault}, {31'd0, ec != 0});
    chk(lin_addr == exp_lin, {"R5 R12 linear ", tag}, lin_addr, exp_lin);
    if (ec == 3'd1) begin
      chk(lat == 1, {"R2 bound latency ", tag}, lat, 1);
      chk(rd_cnt == 0, {"R3 no read ", tag}, rd_cnt, 0);
    end else begin
      chk(lat == 4, {"R2 latency ", tag}, lat, 4);
      chk(rd_cnt == 2 && rd_addr0 == a && rd_addr1 == a + 4, {"R1 read addr ", tag}, rd_addr0, a);
    end
    repeat (2) @(negedge clk);
    chk(done_cnt == 1, {"R2 single done ", tag}, done_cnt, 1);
    if (ec == 3'd0 && !hi[8]) begin
      chk(wr_cnt == 1 && wr_addr == a + 4 && wr_data == (hi | 32'h100),
          {"R11 write-back ", tag}, wr_data, hi | 32'h100);
      chk(mem[a[9:2] + 8'd1] == (hi | 32'h100), {"R11 mem word ", tag}, mem[a[9:2] + 8'd1], hi | 32'h100);
    end else begin
      chk(wr_cnt == 0, {"R11 no write ", tag}, wr_cnt, 0);
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] b, off;
    logic [19:0] l;
    logic [15:0] s;
    bit g, p, sb, a;
    logic [1:0] dpl;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !fault && !mem_rd_en && !mem_wr_en && fault_code == 0 && lin_addr == 0,
        "R12 reset state", {done, fault, mem_rd_en, mem_wr_en, fault_code, lin_addr[26:0]}, 0);

    // R4 R5 byte granularity, offset at limit and one past
    put_desc(16'h0008, mk_lo(32'h1234_5678, 20'h0_0FFF), mk_hi(32'h1234_5678, 20'h0_0FFF, 0, 1, 1, 2'd0, 0));
    run_req(16'h0008, 32'h0000_0FFF, 2'd0, 0, "R9 byte at limit");
    run_req(16'h0008, 32'h0000_1000, 2'd0, 0, "R9 byte past limit");
    // R9 page granularity
    put_desc(16'h0010, mk_lo(32'hA000_0000, 20'h0_0003), mk_hi(32'hA000_0000, 20'h0_0003, 1, 1, 1, 2'd3, 0));
    run_req(16'h0013, 32'h0000_3FFF, 2'd3, 0, "R9 page at limit");
    run_req(16'h0013, 32'h0000_4000, 2'd3, 0, "R9 page past limit");
    // R6 R10 not present wins over privilege
    put_desc(16'h0018, mk_lo(32'h0, 20'hFFFFF), mk_hi(32'h0, 20'hFFFFF, 1, 0, 0, 2'd0, 0));
    run_req(16'h001B, 32'h0, 2'd3, 0, "R6 R10 not present");
    // R7 system descriptor
    put_desc(16'h0020, mk_lo(32'h0, 20'hFFFFF), mk_hi(32'h0, 20'hFFFFF, 1, 1, 0, 2'd3, 0));
    run_req(16'h0020, 32'h0, 2'd0, 0, "R7 system");
    // R8 privilege from RPL and from CPL, and equal case
    put_desc(16'h0028, mk_lo(32'h100, 20'hFFFFF), mk_hi(32'h100, 20'hFFFFF, 0, 1, 1, 2'd2, 1));
    run_req(16'h002B, 32'h5, 2'd0, 0, "R8 rpl above dpl");
    run_req(16'h0028, 32'h5, 2'd3, 0, "R8 cpl above dpl");
    run_req(16'h002A, 32'h5, 2'd1, 0, "R8 R11 equal, accessed set");
    // R3 table bounds
    put_desc(16'h0078, mk_lo(32'h77, 20'hFF), mk_hi(32'h77, 20'hFF, 0, 1, 1, 2'd3, 0));
    run_req(16'h0078, 32'h1, 2'd0, 0, "R3 last global entry");
    run_req(16'h0080, 32'h1, 2'd0, 0, "R3 global beyond");
    run_req(16'h0044, 32'h1, 2'd0, 0, "R3 local beyond");
    // R1 local table and R2 start while busy ignored
    put_desc(16'h001C, mk_lo(32'hFFFF_FFF0, 20'hFFFFF), mk_hi(32'hFFFF_FFF0, 20'hFFFFF, 1, 1, 1, 2'd3, 0));
    run_req(16'h001C, 32'h0000_0020, 2'd1, 1, "R1 R2 local, busy start");

    for (int n = 0; n < 300; n++) begin
      s = 16'($urandom_range(1, 0) ? (($urandom_range(9, 0) << 3) | 4) : ($urandom_range(19, 0) << 3));
      s[1:0] = 2'($urandom_range(3, 0));
      b = $urandom; l = 20'($urandom);
      if ($urandom_range(1, 0) == 1) l = 20'($urandom_range(255, 0));
      g = 1'($urandom_range(1, 0)); p = ($urandom_range(7, 0) != 0);
      sb = ($urandom_range(7, 0) != 0); dpl = 2'($urandom_range(3, 0));
      a = 1'($urandom_range(1, 0));
      if (({16'd0, s[15:3], 3'b111}) <= {16'd0, s[2] ? ldt_limit : gdt_limit})
        put_desc(s, mk_lo(b, l), mk_hi(b, l, g, p, sb, dpl, a));
      case ($urandom_range(2, 0))
        0: off = $urandom;
        1: off = g ? {l, 12'hFFF} : {12'd0, l};
        default: off = (g ? {l, 12'hFFF} : {12'd0, l}) + 32'd1;
      endcase
      run_req(s, off, 2'($urandom_range(3, 0)), ($urandom_range(9, 0) == 0), "random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule